// File: doc/BRIEF.md
# Banked Data-Window Decoder

This block sits on the data-space bus of a small 8-bit controller, between the core and its memories. It holds a write-only bank selector that is mapped at data address E8h. Every access that falls in the low 64-byte window (00h to 3Fh) is steered to one of three memories by that selector. The default RAM is used when the selector is zero. An extra RAM page is used when selector bit 4 is the only bit set. An EEPROM page is used when bit 0 is the only bit set. Addresses outside the window, other than E8h, always go to the default RAM.

The core always addresses a banked byte as if it sat in bank 0. The block passes the low six address bits on as the offset inside the chosen page. It raises one chip select per memory and multiplexes the matching read data back to the core.

The selector has no reset. Until software first writes it, a status output shows that it is unwritten, and window accesses reach no memory. Selector values that are not legal raise an error flag and block every window chip select, so two memories never drive the read bus together. Set-bit and clear-bit operations aimed at E8h are ignored.

Top module: `bank_window_decoder`

## Requirements
- R1: A byte write (`wr_en`=1, `bitop`=0) to address E8h loads `wdata` into the selector at that clock edge. An access in the very next cycle already uses the new bank.
- R2: A write to E8h with `bitop`=1 leaves the selector and the unwritten status unchanged.
- R3: An access to E8h asserts no chip select. A read of E8h returns 00h on `rdata`.
- R4: `sel_unwritten` is 1 from reset until the first byte write to E8h, and 0 afterwards. While it is 1, window accesses assert no chip select, and reads from the window return 00h.
- R5: With selector 10h, a window access asserts `xram_cs` and returns `xram_rdata` on reads.
- R6: With selector 01h, a window access asserts `eep_cs` and returns `eep_rdata` on reads.
- R7: With selector 00h, a window access asserts `ram_cs` and returns `ram_rdata` on reads.
- R8: `sel_err` is 1 when the selector has been written and holds any value other than 00h, 01h or 10h. While it is 1, window accesses assert no chip select, and reads from the window return 00h.
- R9: An access to any address from 40h to FFh other than E8h asserts `ram_cs`, whatever the selector holds or whether it has been written.
- R10: No chip select is asserted while both `rd_en` and `wr_en` are 0, and at most one chip select is asserted at any time. `rdata` is 00h when `rd_en` is 0.
- R11: `local_addr` equals `addr` with bits 7 and 6 cleared for window addresses, and equals `addr` unchanged elsewhere. The window boundary lies between 3Fh and 40h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears only the written status |
| addr | input | 8 | Data-space address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| bitop | input | 1 | Access is a single-bit set or clear operation |
| ram_rdata | input | 8 | Read data from the default RAM |
| xram_rdata | input | 8 | Read data from the extra RAM page |
| eep_rdata | input | 8 | Read data from the EEPROM page |
| ram_cs | output | 1 | Default RAM select |
| xram_cs | output | 1 | Extra RAM page select |
| eep_cs | output | 1 | EEPROM page select |
| local_addr | output | 8 | Address offset presented to the selected memory |
| rdata | output | 8 | Read data returned to the core |
| sel_err | output | 1 | Selector holds an illegal value |
| sel_unwritten | output | 1 | Selector not written since reset |

## Verification
The hardest condition to reach from the ports is the selector's own content. It cannot be read back, so the bench can only infer it from which chip select rises on a later window access. A bit-operation write to E8h must therefore be followed by a window probe that still shows the old bank, both before the first real write and after it.

Illegal values are reached by ordinary byte writes of mixed and reserved bit patterns. Each such write is paired with an out-of-window probe, which shows that default decoding is unaffected by the illegal value.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  parameter int unsigned BWD_AW = 8;
  parameter int unsigned BWD_DW = 8;

  typedef logic [BWD_AW-1:0] addr_t;
  typedef logic [BWD_DW-1:0] word_t;

  typedef enum logic [1:0] {
    BANK_DEFAULT,
    BANK_XRAM,
    BANK_EEP,
    BANK_ILLEGAL
  } bank_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_XRAM,
    TGT_EEP,
    TGT_REG
  } tgt_e;

  // classify a selector value into a bank
  function automatic bank_e classify_bank(input word_t v, input int xbit, input int ebit);
    word_t xmask;
    word_t emask;
    xmask = word_t'(1) << xbit;
    emask = word_t'(1) << ebit;
    if (v == '0)         return BANK_DEFAULT;
    else if (v == xmask) return BANK_XRAM;
    else if (v == emask) return BANK_EEP;
    else                 return BANK_ILLEGAL;
  endfunction

  // address lies in the banked low window
  function automatic logic in_window(input addr_t a, input int win_bits);
    return (a >> win_bits) == '0;
  endfunction

  // offset inside a page: only the low window bits survive
  function automatic addr_t window_offset(input addr_t a, input int win_bits);
    addr_t mask;
    mask = (addr_t'(1) << win_bits) - addr_t'(1);
    return a & mask;
  endfunction

endpackage

// File: rtl/bwd_bank_reg.sv
module bwd_bank_reg
  import bwd_pkg::*;
#(
  parameter addr_t REG_ADDR = 8'hE8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t addr,
  input  word_t wdata,
  input  logic  wr_en,
  input  logic  bitop,
  output word_t bank_q,
  output logic  written
);

  logic reg_hit;
  logic load_evt;
  logic bitop_hit;

  assign reg_hit   = (addr == REG_ADDR);
  assign load_evt  = reg_hit && wr_en && !bitop;
  assign bitop_hit = reg_hit && wr_en && bitop;

  // selector contents: deliberately without reset
  always_ff @(posedge clk) begin
    if (load_evt) bank_q <= wdata;
  end

  // written status: the only reset state in the block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        written <= 1'b0;
    else if (load_evt) written <= 1'b1;
  end

  // R2
  bitop_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitop_hit |=> $stable(bank_q) && $stable(written));

  // R4
  written_only_by_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(written) |-> $past(load_evt));

  // R1
  load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> bank_q == $past(wdata));

endmodule

// File: rtl/bwd_route.sv
module bwd_route
  import bwd_pkg::*;
#(
  parameter int    WIN_BITS = 6,
  parameter addr_t REG_ADDR = 8'hE8,
  parameter int    XRAM_BIT = 4,
  parameter int    EEP_BIT  = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t addr,
  input  logic  rd_en,
  input  logic  wr_en,
  input  word_t bank_q,
  input  logic  written,
  output tgt_e  tgt,
  output addr_t local_addr,
  output logic  sel_err,
  output logic  ram_cs,
  output logic  xram_cs,
  output logic  eep_cs
);

  logic  win_hit;
  logic  reg_hit;
  logic  strobe;
  bank_e bank_cls;

  assign win_hit  = in_window(addr, WIN_BITS);
  assign reg_hit  = (addr == REG_ADDR);
  assign strobe   = rd_en || wr_en;
  assign bank_cls = classify_bank(bank_q, XRAM_BIT, EEP_BIT);
  assign sel_err  = written && (bank_cls == BANK_ILLEGAL);

  always_comb begin
    tgt = TGT_NONE;
    if (!strobe) begin
      tgt = TGT_NONE;
    end else if (reg_hit) begin
      tgt = TGT_REG;
    end else if (!win_hit) begin
      tgt = TGT_RAM;
    end else if (written) begin
      unique case (bank_cls)
        BANK_DEFAULT: tgt = TGT_RAM;
        BANK_XRAM:    tgt = TGT_XRAM;
        BANK_EEP:     tgt = TGT_EEP;
        default:      tgt = TGT_NONE;
      endcase
    end
  end

  assign ram_cs     = (tgt == TGT_RAM);
  assign xram_cs    = (tgt == TGT_XRAM);
  assign eep_cs     = (tgt == TGT_EEP);
  assign local_addr = win_hit ? window_offset(addr, WIN_BITS) : addr;

  // R10
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, xram_cs, eep_cs}));

  // R10
  idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> !(ram_cs || xram_cs || eep_cs));

  // R3
  reg_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> !(ram_cs || xram_cs || eep_cs));

  // R8
  illegal_blocks_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_err && win_hit) |-> !(ram_cs || xram_cs || eep_cs));

  // R4
  unwritten_blocks_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!written && win_hit) |-> !(ram_cs || xram_cs || eep_cs));

  // R9
  outside_goes_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit && !reg_hit && strobe) |-> ram_cs);

endmodule

// File: rtl/bwd_rdmux.sv
module bwd_rdmux
  import bwd_pkg::*;
(
  input  tgt_e  tgt,
  input  logic  rd_en,
  input  word_t ram_rdata,
  input  word_t xram_rdata,
  input  word_t eep_rdata,
  output word_t rdata
);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (tgt)
        TGT_RAM:  rdata = ram_rdata;
        TGT_XRAM: rdata = xram_rdata;
        TGT_EEP:  rdata = eep_rdata;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
  import bwd_pkg::*;
#(
  parameter int         WIN_BITS = 6,
  parameter logic [7:0] REG_ADDR = 8'hE8,
  parameter int         XRAM_BIT = 4,
  parameter int         EEP_BIT  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic       bitop,
  input  logic [7:0] ram_rdata,
  input  logic [7:0] xram_rdata,
  input  logic [7:0] eep_rdata,
  output logic       ram_cs,
  output logic       xram_cs,
  output logic       eep_cs,
  output logic [7:0] local_addr,
  output logic [7:0] rdata,
  output logic       sel_err,
  output logic       sel_unwritten
);

  word_t bank_q;
  logic  written;
  tgt_e  tgt;

  bwd_bank_reg #(.REG_ADDR(REG_ADDR)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .bitop   (bitop),
    .bank_q  (bank_q),
    .written (written)
  );

  bwd_route #(
    .WIN_BITS (WIN_BITS),
    .REG_ADDR (REG_ADDR),
    .XRAM_BIT (XRAM_BIT),
    .EEP_BIT  (EEP_BIT)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .bank_q     (bank_q),
    .written    (written),
    .tgt        (tgt),
    .local_addr (local_addr),
    .sel_err    (sel_err),
    .ram_cs     (ram_cs),
    .xram_cs    (xram_cs),
    .eep_cs     (eep_cs)
  );

  bwd_rdmux u_mux (
    .tgt        (tgt),
    .rd_en      (rd_en),
    .ram_rdata  (ram_rdata),
    .xram_rdata (xram_rdata),
    .eep_rdata  (eep_rdata),
    .rdata      (rdata)
  );

  assign sel_unwritten = !written;

  // R10
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);

endmodule

// File: tb/test_bank_window_decoder.sv
module test_bank_window_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       rd_en = 1'b0, wr_en = 1'b0, bitop = 1'b0;
  logic [7:0] ram_rdata = 8'hA1, xram_rdata = 8'hB2, eep_rdata = 8'hC3;
  logic       ram_cs, xram_cs, eep_cs, sel_err, sel_unwritten;
  logic [7:0] local_addr, rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_window_decoder i_bank_window_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .bitop(bitop), .ram_rdata(ram_rdata),
    .xram_rdata(xram_rdata), .eep_rdata(eep_rdata), .ram_cs(ram_cs),
    .xram_cs(xram_cs), .eep_cs(eep_cs), .local_addr(local_addr),
    .rdata(rdata), .sel_err(sel_err), .sel_unwritten(sel_unwritten)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // selects as {ram, xram, eep}
  function automatic logic [7:0] cs_vec();
    return {5'b0, ram_cs, xram_cs, eep_cs};
  endfunction

  // byte or bit write; starts and ends at a falling edge
  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic bop);
    addr = a; wdata = d; wr_en = 1'b1; bitop = bop;
    @(negedge clk);
    wr_en = 1'b0; bitop = 1'b0;
  endtask

  // read probe with expected selects, data and offset
  task automatic probe(input string req, input logic [7:0] a, input logic [7:0] exp_cs,
                       input logic [7:0] exp_data, input logic [7:0] exp_loc);
    addr = a; rd_en = 1'b1;
    #2;
    chk(req, "selects", cs_vec(), exp_cs);
    chk(req, "rdata", rdata, exp_data);
    chk(req, "local_addr", local_addr, exp_loc);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    chk("R4", "unwritten after reset", {7'b0, sel_unwritten}, 8'h01);
    chk("R8", "err after reset", {7'b0, sel_err}, 8'h00);
    addr = 8'h10;
    chk("R10", "idle selects", cs_vec(), 8'h00);
    chk("R10", "idle rdata", rdata, 8'h00);
    @(negedge clk);
    probe("R4", 8'h20, 8'h00, 8'h00, 8'h20);
    probe("R9", 8'h80, 8'h04, 8'hA1, 8'h80);
  endtask

  task automatic t_first_write();
    do_write(8'hE8, 8'h10, 1'b1);
    chk("R2", "bitop keeps unwritten", {7'b0, sel_unwritten}, 8'h01);
    probe("R2", 8'h05, 8'h00, 8'h00, 8'h05);
    do_write(8'hE8, 8'h10, 1'b0);
    #1;
    chk("R4", "written after load", {7'b0, sel_unwritten}, 8'h00);
    #1;
    probe("R1", 8'h25, 8'h02, 8'hB2, 8'h25);
  endtask

  task automatic t_xram_and_reg();
    probe("R5", 8'h00, 8'h02, 8'hB2, 8'h00);
    probe("R11", 8'h3F, 8'h02, 8'hB2, 8'h3F);
    probe("R11", 8'h40, 8'h04, 8'hA1, 8'h40);
    probe("R3", 8'hE8, 8'h00, 8'h00, 8'hE8);
    addr = 8'h11; wr_en = 1'b1;
    #2;
    chk("R5", "write selects", cs_vec(), 8'h02);
    chk("R10", "rdata on write", rdata, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_bitop_after_load();
    do_write(8'hE8, 8'h01, 1'b1);
    probe("R2", 8'h30, 8'h02, 8'hB2, 8'h30);
  endtask

  task automatic t_eep_and_default();
    do_write(8'hE8, 8'h01, 1'b0);
    probe("R6", 8'h00, 8'h01, 8'hC3, 8'h00);
    probe("R6", 8'h3E, 8'h01, 8'hC3, 8'h3E);
    do_write(8'hE8, 8'h00, 1'b0);
    probe("R7", 8'h12, 8'h04, 8'hA1, 8'h12);
    chk("R8", "no err on 00h", {7'b0, sel_err}, 8'h00);
  endtask

  task automatic t_illegal();
    logic [7:0] bad [3] = '{8'h11, 8'h20, 8'h02};
    foreach (bad[i]) begin
      do_write(8'hE8, bad[i], 1'b0);
      #1;
      chk("R8", "err flag", {7'b0, sel_err}, 8'h01);
      #1;
      probe("R8", 8'h05, 8'h00, 8'h00, 8'h05);
      probe("R9", 8'hC0, 8'h04, 8'hA1, 8'hC0);
    end
    do_write(8'hE8, 8'h10, 1'b0);
    #1;
    chk("R8", "err clears", {7'b0, sel_err}, 8'h00);
    #1;
    probe("R5", 8'h07, 8'h02, 8'hB2, 8'h07);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_write();
    t_xram_and_reg();
    t_bitop_after_load();
    t_eep_and_default();
    t_illegal();
    finish_run();
  end

endmodule